// File: doc/BRIEF.md
# Doorbell and Interrupt Register Block

This block is the small register window of an adapter that lets several domains share one memory region. A 32-bit register bus reaches four word registers within a 256-byte window: an interrupt mask, an interrupt status, a read-only position register that reports the local peer number, and a write-only doorbell. A single level interrupt is raised while any status bit is also enabled in the mask. Reading the status register consumes it: the value is returned and the register is cleared.

A doorbell write carries a destination peer number in its upper half and a vector number in its low byte. The block checks the destination against the highest known peer number and against the vector count that the peer table gives for that destination. An accepted doorbell leaves as a one-cycle notify pulse with the destination and vector beside it. A rejected one is dropped silently. A side input from the event path can load a byte into the status register directly.

Top module: `dbr_regs`

## Requirements
- R1: `irq_o` is high exactly when status AND mask is nonzero. It follows every mask or status change in the cycle after the clock edge that made the change.
- R2: A read at byte address 0x04 returns the status value held before the edge. From the next cycle status is zero and `irq_o` is low, unless R12 or a same-cycle status write applies.
- R3: A write at address 0x04 replaces all 32 status bits with the write data. It is not a write-one-to-clear.
- R4: A write at address 0x00 sets the 32-bit mask, and a read at 0x00 returns it. Reset does not change the mask.
- R5: Reset clears status to zero and holds `irq_o` low.
- R6: For writes, address bits [1:0] are ignored (for example, a write at 0x05 reaches status). Reads decode the full byte address.
- R7: A read at any address other than 0x00, 0x04 or 0x08 returns zero and changes no state. This covers unaligned addresses and the doorbell at 0x0C.
- R8: A read at 0x08 returns `own_id_i` zero-extended while `mapped_i` is high, and 0xFFFFFFFF while it is low.
- R9: A write at 0x0C with destination = data[31:16] and vector = data[7:0] that passes R10 and R11 produces `notify_o` high for exactly the next cycle. In that cycle `notify_peer_o` is the destination and `notify_vec_o` is the vector.
- R10: A doorbell whose destination is greater than `max_peer_i`, or not below NUM_PEERS, produces no notify pulse.
- R11: A doorbell whose vector is not below the destination's count produces no notify pulse. The count for peer p is `peer_vec_cnt_i[p*CNT_W +: CNT_W]`.
- R12: While `set_valid_i` is high, status becomes {24'b0, `set_byte_i`} at the edge. This takes priority over a bus status write and over the clear from a same-cycle status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address within the window |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle `re_i` is high |
| set_valid_i | input | 1 | Load the status register from `set_byte_i` |
| set_byte_i | input | 8 | Byte loaded into the low status bits |
| own_id_i | input | 16 | Local peer number |
| mapped_i | input | 1 | Shared memory is mapped |
| max_peer_i | input | 16 | Highest known peer number |
| peer_vec_cnt_i | input | NUM_PEERS*CNT_W | Vector count for each peer |
| irq_o | output | 1 | Level interrupt |
| notify_o | output | 1 | One-cycle pulse for an accepted doorbell |
| notify_peer_o | output | 16 | Destination of the accepted doorbell |
| notify_vec_o | output | 8 | Vector of the accepted doorbell |

## Verification
A corrupted status or mask register shows on `irq_o` in the cycle after the faulty edge. It also shows in the value of the next status or mask read. A status register that fails to clear on a read shows on the next read and keeps the interrupt asserted. A wrong range check in the doorbell path shows in the cycle right after the write, either as a missing pulse or as an unexpected one. Each stimulus is therefore followed at once by a port observation, so a fault shows within one or two cycles.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int ID_W   = 16;
  localparam int VEC_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_POS  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_BELL = 8'h0C;

  // writes ignore the byte-lane bits
  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] a);
    return a & 8'hFC;
  endfunction
endpackage

// File: rtl/dbr_status_unit.sv
module dbr_status_unit
  import dbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic              stat_we_i,
  input  logic              stat_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              set_valid_i,
  input  logic [VEC_W-1:0]  set_byte_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mask_q, stat_q, stat_d;

  // mask survives reset by intent
  always_ff @(posedge clk_i) begin
    if (mask_we_i) mask_q <= wdata_i;
  end

  always_comb begin
    stat_d = stat_q;
    if (set_valid_i)    stat_d = {{(DATA_W-VEC_W){1'b0}}, set_byte_i};
    else if (stat_we_i) stat_d = wdata_i;
    else if (stat_rd_i) stat_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_q);

  p_clear_on_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !set_valid_i && !stat_we_i) |=> (stat_o == '0 && !irq_o));

  p_set_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_valid_i |=> stat_o == {{(DATA_W-VEC_W){1'b0}}, $past(set_byte_i)});
endmodule

// File: rtl/dbr_bell_unit.sv
module dbr_bell_unit
  import dbr_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int CNT_W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bell_we_i,
  input  logic [ID_W-1:0]            dest_i,
  input  logic [VEC_W-1:0]           vec_i,
  input  logic [ID_W-1:0]            max_peer_i,
  input  logic [NUM_PEERS*CNT_W-1:0] peer_vec_cnt_i,
  output logic                       notify_o,
  output logic [ID_W-1:0]            notify_peer_o,
  output logic [VEC_W-1:0]           notify_vec_o
);
  localparam int IDX_W = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1;
  localparam logic [ID_W-1:0] PEERS_L = ID_W'(NUM_PEERS);

  logic [CNT_W-1:0] cnt_arr [NUM_PEERS];
  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_cnt
    assign cnt_arr[p] = peer_vec_cnt_i[p*CNT_W +: CNT_W];
  end

  logic             peer_ok, vec_ok, accept;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt_sel;

  assign idx     = dest_i[IDX_W-1:0];
  assign peer_ok = (dest_i <= max_peer_i) && (dest_i < PEERS_L);
  assign cnt_sel = peer_ok ? cnt_arr[idx] : '0;
  assign vec_ok  = 32'(vec_i) < 32'(cnt_sel);
  assign accept  = bell_we_i && peer_ok && vec_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      notify_o      <= 1'b0;
      notify_peer_o <= '0;
      notify_vec_o  <= '0;
    end else begin
      notify_o <= accept;
      if (accept) begin
        notify_peer_o <= dest_i;
        notify_vec_o  <= vec_i;
      end
    end
  end

  p_drop_peer_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bell_we_i && dest_i > max_peer_i) |=> !notify_o);

  p_drop_vec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bell_we_i && dest_i < PEERS_L && 32'(vec_i) >= 32'(cnt_arr[idx])) |=> !notify_o);
endmodule

// File: rtl/dbr_regs.sv
module dbr_regs
  import dbr_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int CNT_W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       we_i,
  input  logic                       re_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic                       set_valid_i,
  input  logic [VEC_W-1:0]           set_byte_i,
  input  logic [ID_W-1:0]            own_id_i,
  input  logic                       mapped_i,
  input  logic [ID_W-1:0]            max_peer_i,
  input  logic [NUM_PEERS*CNT_W-1:0] peer_vec_cnt_i,
  output logic                       irq_o,
  output logic                       notify_o,
  output logic [ID_W-1:0]            notify_peer_o,
  output logic [VEC_W-1:0]           notify_vec_o
);
  logic [ADDR_W-1:0] waddr;
  logic              mask_we, stat_we, bell_we, stat_rd;
  logic [DATA_W-1:0] mask_q, stat_q;

  assign waddr   = word_addr(addr_i);
  assign mask_we = we_i && (waddr == OFS_MASK);
  assign stat_we = we_i && (waddr == OFS_STAT);
  assign bell_we = we_i && (waddr == OFS_BELL);
  assign stat_rd = re_i && (addr_i == OFS_STAT);

  dbr_status_unit u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_we_i   (mask_we),
    .stat_we_i   (stat_we),
    .stat_rd_i   (stat_rd),
    .wdata_i     (wdata_i),
    .set_valid_i (set_valid_i),
    .set_byte_i  (set_byte_i),
    .mask_o      (mask_q),
    .stat_o      (stat_q),
    .irq_o       (irq_o)
  );

  dbr_bell_unit #(.NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W)) u_bell (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bell_we_i      (bell_we),
    .dest_i         (wdata_i[31:16]),
    .vec_i          (wdata_i[7:0]),
    .max_peer_i     (max_peer_i),
    .peer_vec_cnt_i (peer_vec_cnt_i),
    .notify_o       (notify_o),
    .notify_peer_o  (notify_peer_o),
    .notify_vec_o   (notify_vec_o)
  );

  // reads decode the full byte address
  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (addr_i)
        OFS_MASK: rdata_o = mask_q;
        OFS_STAT: rdata_o = stat_q;
        OFS_POS:  rdata_o = mapped_i ? {{(DATA_W-ID_W){1'b0}}, own_id_i} : '1;
        default:  rdata_o = '0;
      endcase
    end
  end

  p_notify_from_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> $past(we_i && word_addr(addr_i) == OFS_BELL));
endmodule

// File: tb/sim_dbr_regs.sv
module sim_dbr_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int CW = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [31:0]   wdata = '0, rdata;
  logic          set_v = 1'b0;
  logic [7:0]    set_b = '0;
  logic [15:0]   own_id = 16'h0002;
  logic          mapped = 1'b0;
  logic [15:0]   max_peer = 16'd2;
  logic [NP*CW-1:0] cnts = {8'd4, 8'd0, 8'd1, 8'd2};
  logic          irq, notify;
  logic [15:0]   n_peer;
  logic [7:0]    n_vec;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbr_regs #(.NUM_PEERS(NP), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .set_valid_i(set_v), .set_byte_i(set_b),
    .own_id_i(own_id), .mapped_i(mapped), .max_peer_i(max_peer),
    .peer_vec_cnt_i(cnts), .irq_o(irq), .notify_o(notify),
    .notify_peer_o(n_peer), .notify_vec_o(n_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R5 irq after reset", 32'(irq), 0);
    rd(8'h04, d); chk("R5 status after reset", d, 0);
    chk("R9 no notify after reset", 32'(notify), 0);
  endtask

  task automatic t_irq_level();
    logic [31:0] d;
    wr(8'h00, 32'h0000_0003); rd(8'h00, d); chk("R4 mask readback", d, 32'h3);
    wr(8'h04, 32'h0000_0004); chk("R1 no overlap irq low", 32'(irq), 0);
    wr(8'h04, 32'h0000_0006); chk("R1 overlap irq high", 32'(irq), 1);
    wr(8'h00, 32'h0000_0000); chk("R1 mask cleared irq low", 32'(irq), 0);
    wr(8'h00, 32'h8000_0000); wr(8'h04, 32'h8000_0000);
    chk("R1 top bit irq high", 32'(irq), 1);
  endtask

  task automatic t_clear_on_read();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hA5A5_0F0F);
    chk("R1 irq before read", 32'(irq), 1);
    rd(8'h04, d); chk("R2 read returns value", d, 32'hA5A5_0F0F);
    chk("R2 irq low after read", 32'(irq), 0);
    rd(8'h04, d); chk("R2 second read zero", d, 0);
  endtask

  task automatic t_replace();
    logic [31:0] d;
    wr(8'h04, 32'h0000_00F0); wr(8'h04, 32'h0000_0001);
    rd(8'h04, d); chk("R3 status replaced not w1c", d, 32'h1);
    wr(8'h05, 32'h0000_0077);
    rd(8'h04, d); chk("R6 unaligned write reaches status", d, 32'h77);
  endtask

  task automatic t_undecoded();
    logic [31:0] d;
    wr(8'h04, 32'h0000_0055);
    rd(8'h05, d); chk("R7 unaligned read zero", d, 0);
    rd(8'h0C, d); chk("R7 doorbell read zero", d, 0);
    rd(8'h40, d); chk("R7 high offset zero", d, 0);
    rd(8'h04, d); chk("R7 no side effect on status", d, 32'h55);
  endtask

  task automatic t_position();
    logic [31:0] d;
    mapped = 1'b0; rd(8'h08, d); chk("R8 unmapped all ones", d, 32'hFFFF_FFFF);
    mapped = 1'b1; rd(8'h08, d); chk("R8 mapped own id", d, 32'h2);
  endtask

  task automatic t_doorbell();
    wr(8'h0C, 32'h0000_0001);
    chk("R9 valid pulse", 32'(notify), 1);
    chk("R9 peer", 32'(n_peer), 0); chk("R9 vector", 32'(n_vec), 1);
    @(negedge clk); chk("R9 pulse one cycle", 32'(notify), 0);
    wr(8'h0C, 32'h0001_FF00);
    chk("R9 vec from low byte", 32'(notify), 1);
    chk("R9 peer 1", 32'(n_peer), 1); chk("R9 vector 0", 32'(n_vec), 0);
    wr(8'h0C, 32'h0003_0000); chk("R10 dest above max dropped", 32'(notify), 0);
    wr(8'h0C, 32'h0005_0000); chk("R10 dest beyond table dropped", 32'(notify), 0);
    wr(8'h0C, 32'h0000_0002); chk("R11 vec at count dropped", 32'(notify), 0);
    wr(8'h0C, 32'h0002_0000); chk("R11 zero count dropped", 32'(notify), 0);
    max_peer = 16'd3;
    wr(8'h0D, 32'h0003_0003); chk("R10 raised max accepts", 32'(notify), 1);
    chk("R9 peer 3", 32'(n_peer), 3);
    max_peer = 16'd2;
  endtask

  task automatic t_ext_set();
    logic [31:0] d;
    wr(8'h00, 32'h0000_0080); wr(8'h04, 32'hFFFF_0000);
    @(negedge clk); set_b = 8'h81; set_v = 1'b1;
    @(negedge clk); set_v = 1'b0;
    chk("R12 set drives irq", 32'(irq), 1);
    rd(8'h04, d); chk("R12 set replaces status", d, 32'h81);
    wr(8'h04, 32'h0000_0011);
    @(negedge clk); addr = 8'h04; re = 1'b1; set_b = 8'h90; set_v = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0; set_v = 1'b0;
    chk("R12 read returns old", d, 32'h11);
    chk("R12 set wins irq", 32'(irq), 1);
    rd(8'h04, d); chk("R12 set wins over clear", d, 32'h90);
  endtask

  task automatic t_reset_mask();
    logic [31:0] d;
    wr(8'h00, 32'h00FF_00FF); wr(8'h04, 32'h0000_0001);
    chk("R1 irq before reset", 32'(irq), 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    chk("R5 irq low after reset", 32'(irq), 0);
    rd(8'h00, d); chk("R4 mask kept over reset", d, 32'h00FF_00FF);
    rd(8'h04, d); chk("R5 status cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_irq_level();
    t_clear_on_read();
    t_replace();
    t_undecoded();
    t_position();
    t_doorbell();
    t_ext_set();
    t_reset_mask();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule